// File: doc/BRIEF.md
# Strobe-Acknowledge Bus Slave Port

This block lets a processor with an asynchronous, strobe-based bus and dynamic bus sizing reach an internal 16-bit register or memory array. The processor marks a cycle by pulling the address strobe low with the chip select active. The slave then latches the 17-bit byte address, the transfer size and the direction, and passes a word address and byte enables to the array. It ends the cycle with a single acknowledge line, which tells the processor that the port is 16 bits wide. Data travels only on the upper half of the 32-bit data bus. The two outputs meant for tri-state pads, the acknowledge and the upper data lanes, each come out as a value and an enable.

All logic runs on the bus clock. Strobes and controls are assumed to meet setup to that clock. The array answers a request with a ready pulse, and the slave adds one wait state for each cycle that ready stays low. Outside a cycle the slave holds every enable low and waits for the strobe, so the bus clock may be stopped low between accesses.

Top module: `strobe_ack_slave`

## Requirements
- R1: After reset and between cycles, `ack_oe`, `dbus_oe` and `arr_req` are low.
- R2: On the first clock edge that samples `as_n` low with `cs_n` low, the slave starts driving the acknowledge (`ack_oe`=1) at its inactive level (`ack_n_out`=1).
- R3: The acknowledge goes low on the clock edge after the one that samples `arr_req` and `arr_ready` both high. With `arr_ready` answering at once, this is the second edge after the strobe is seen. Each cycle of delay in `arr_ready` adds exactly one edge.
- R4: In a read (`rd_wr_n`=1), `dbus_oe` rises and `dbus_out` carries the array word on the same edge at which `ack_n_out` falls.
- R5: In a write (`rd_wr_n`=0), `arr_req` stays low until a clock edge has sampled `ds_n` low. The array then receives `arr_we`=1 and `arr_wdata` equal to `dbus_in`.
- R6: A byte transfer (`siz`=01) or an odd address (`addr[0]`=1) enables one lane only. An even address gives `arr_be`=10, the upper lane `dbus_in[15:8]`. An odd address gives `arr_be`=01. Every other transfer gives `arr_be`=11. `arr_addr` is `addr[16:1]`.
- R7: On the edge after `as_n` is sampled high, the acknowledge is driven high and `dbus_oe` drops. On the next edge `ack_oe` drops.
- R8: A strobe with `cs_n` high is ignored: `ack_oe`, `dbus_oe` and `arr_req` stay low.
- R9: If `as_n` rises before the array is ready, the acknowledge never goes low and the slave releases the bus as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 for read, 0 for write |
| siz | input | 2 | Transfer size code, 01 for a byte |
| addr | input | 17 | Byte address |
| dbus_in | input | 16 | Upper data lanes from the bus |
| dbus_out | output | 16 | Upper data lanes toward the bus |
| dbus_oe | output | 1 | Drive enable for the upper data lanes |
| ack_n_out | output | 1 | Acknowledge level, active low |
| ack_oe | output | 1 | Drive enable for the acknowledge |
| arr_req | output | 1 | Access request to the array |
| arr_we | output | 1 | Write flag for the array |
| arr_addr | output | 16 | Word address to the array |
| arr_be | output | 2 | Byte enables, bit 1 for the upper lane |
| arr_wdata | output | 16 | Write data to the array |
| arr_rdata | input | 16 | Read data from the array |
| arr_ready | input | 1 | Array completion |

## Verification
The bench measures the clock edges from the strobe to the acknowledge, with zero, one and several wait states. A slave that ignored ready, or added an extra register stage, would then report the wrong count. It writes single bytes to even and odd addresses and reads the words back. A swapped lane mapping would corrupt the wrong half, and a byte access decoded as a word would overwrite both halves. It also covers a write whose data strobe arrives late, where a request issued too early would store stale data. It checks a strobe without chip select and an aborted cycle, where a slave that asserted or kept driving its lines would collide with other bus users.

// File: rtl/strobe_ack_pkg.sv
// Shared types for the strobe-acknowledge slave.
package strobe_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_REL  = 2'd3
    } sab_state_e;

    localparam logic [1:0] SIZ_BYTE = 2'b01;
endpackage

// File: rtl/sab_lane_decode.sv
// Byte-lane decoder. It turns the size code and the low address bit into
// enables for a 16-bit port, with the even byte on the upper lane.
// Assumes two lanes, so the enable for the even byte is bit 1.
module sab_lane_decode
    import strobe_ack_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [1:0]       siz,
    input  logic             addr_lsb,
    output logic [LANES-1:0] be
);
    logic single_lane;

    // Purpose: pick a single lane for bytes and odd addresses, else both.
    always_comb begin
        single_lane = (siz == SIZ_BYTE) || addr_lsb;
        if (single_lane) begin
            be = addr_lsb ? LANES'(2'b01) : LANES'(2'b10);
        end else begin
            be = '1;
        end
    end
endmodule

// File: rtl/sab_cycle_fsm.sv
// Bus cycle sequencer. It tracks one strobe cycle from the strobe sample to
// the release and produces the acknowledge, the enables and the array request.
// Assumes the strobes are already timed to clk.
module sab_cycle_fsm
    import strobe_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic ds_n,
    input  logic cs_n,
    input  logic rd_wr_n,
    input  logic arr_ready,
    output logic start,
    output logic load_rdata,
    output logic cyc_rd,
    output logic arr_req,
    output logic ack_n_out,
    output logic ack_oe,
    output logic dbus_oe
);
    sab_state_e state;
    logic       ds_seen;

    assign start      = (state == ST_IDLE) && !as_n && !cs_n;
    assign arr_req    = (state == ST_WAIT) && !as_n && (cyc_rd || ds_seen);
    assign load_rdata = arr_req && arr_ready;
    assign ack_oe     = (state != ST_IDLE);
    assign ack_n_out  = (state != ST_ACK);
    assign dbus_oe    = (state == ST_ACK) && cyc_rd;

    // Purpose: advance the cycle state and record the direction and the data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cyc_rd  <= 1'b1;
            ds_seen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ds_seen <= !ds_n;
                    if (start) begin
                        cyc_rd <= rd_wr_n;
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    ds_seen <= ds_seen || !ds_n;
                    if (as_n) begin
                        state <= ST_REL;
                    end else if (load_rdata) begin
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (as_n) begin
                        state <= ST_REL;
                    end
                end
                default: begin
                    state   <= ST_IDLE;
                    ds_seen <= 1'b0;
                end
            endcase
        end
    end

    // R2: a strobe with chip select drives the acknowledge high first
    a_r2_drive_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !as_n && !cs_n) |=> (ack_oe && ack_n_out));

    // R3: the acknowledge falls only after an accepted request
    a_r3_ack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_out) |-> $past(arr_req && arr_ready));

    // R7: the strobe rising releases the acknowledge and the data lanes
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && as_n) |=> (ack_oe && ack_n_out && !dbus_oe));

    // R7: the acknowledge floats one edge after it was driven high
    a_r7_float: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REL) |=> !ack_oe);

    // R8: a strobe without chip select leaves the acknowledge floating
    a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_n) |=> !ack_oe);
endmodule

// File: rtl/sab_datapath.sv
// Address and data holding registers. It latches the word address and the
// lane enables when a cycle starts, and the array word when the array answers.
// Assumes start and load_rdata come from the cycle sequencer.
module sab_datapath
    import strobe_ack_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load_rdata,
    input  logic [1:0]        siz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_in,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-2:0] arr_addr,
    output logic [LANES-1:0]  arr_be,
    output logic [DATA_W-1:0] dbus_out
);
    // Purpose: hold the address and lanes for the whole cycle, and the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_addr <= '0;
            arr_be   <= '0;
            dbus_out <= '0;
        end else begin
            if (start) begin
                arr_addr <= addr[ADDR_W-1:1];
                arr_be   <= be_in;
            end
            if (load_rdata) begin
                dbus_out <= arr_rdata;
            end
        end
    end

    // R6: a byte transfer always enables exactly one lane
    a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (start && siz == SIZ_BYTE) |=> ($countones(arr_be) == 1));
endmodule

// File: rtl/strobe_ack_slave.sv
// Top of the strobe-acknowledge slave port. It joins the lane decoder, the
// cycle sequencer and the holding registers. Acknowledge and data come out as
// value/enable pairs for tri-state pads. Assumes a 16-bit port.
module strobe_ack_slave
    import strobe_ack_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              cs_n,
    input  logic              rd_wr_n,
    input  logic [1:0]        siz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dbus_in,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic              ack_n_out,
    output logic              ack_oe,
    output logic              arr_req,
    output logic              arr_we,
    output logic [ADDR_W-2:0] arr_addr,
    output logic [LANES-1:0]  arr_be,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              arr_ready
);
    logic             start;
    logic             load_rdata;
    logic             cyc_rd;
    logic [LANES-1:0] be_dec;

    assign arr_we    = !cyc_rd;
    assign arr_wdata = dbus_in;

    sab_lane_decode #(.DATA_W(DATA_W)) u_dec (
        .siz      (siz),
        .addr_lsb (addr[0]),
        .be       (be_dec)
    );

    sab_cycle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_n       (as_n),
        .ds_n       (ds_n),
        .cs_n       (cs_n),
        .rd_wr_n    (rd_wr_n),
        .arr_ready  (arr_ready),
        .start      (start),
        .load_rdata (load_rdata),
        .cyc_rd     (cyc_rd),
        .arr_req    (arr_req),
        .ack_n_out  (ack_n_out),
        .ack_oe     (ack_oe),
        .dbus_oe    (dbus_oe)
    );

    sab_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .load_rdata (load_rdata),
        .siz        (siz),
        .addr       (addr),
        .be_in      (be_dec),
        .arr_rdata  (arr_rdata),
        .arr_addr   (arr_addr),
        .arr_be     (arr_be),
        .dbus_out   (dbus_out)
    );
endmodule

// File: tb/strobe_ack_slave_test.sv
// Scoreboard bench: the driver queues the expected read words and the monitor
// compares them on each falling acknowledge of a read.
module strobe_ack_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1, ds_n = 1'b1, cs_n = 1'b1, rd_wr_n = 1'b1;
    logic [1:0]  siz = 2'b10;
    logic [16:0] addr = '0;
    logic [15:0] dbus_in = '0;
    logic [15:0] dbus_out, arr_wdata, arr_rdata;
    logic        dbus_oe, ack_n_out, ack_oe, arr_req, arr_we, arr_ready;
    logic [15:0] arr_addr;
    logic [1:0]  arr_be;

    int checks = 0, fails = 0, cycles = 0, wait_cfg = 0, wcnt = 0;
    logic [15:0] mem [16];
    logic [15:0] exp_mem [16];
    logic [15:0] exp_q [$];
    bit          cur_rd = 1'b0;
    logic        prev_ack_n = 1'b1;

    strobe_ack_slave uut (.*);

    always #10 clk = ~clk;

    // Array model: answers after wait_cfg cycles of request.
    assign arr_ready = arr_req && (wcnt >= wait_cfg);
    assign arr_rdata = mem[arr_addr[3:0]];
    always @(posedge clk) begin
        if (arr_req && !arr_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (arr_req && arr_ready && arr_we) begin
            if (arr_be[1]) mem[arr_addr[3:0]][15:8] <= arr_wdata[15:8];
            if (arr_be[0]) mem[arr_addr[3:0]][7:0]  <= arr_wdata[7:0];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_be(input logic [1:0] sz, input logic a0);
        if (sz == 2'b01 || a0) return a0 ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

    // Monitor: pop and compare on the falling acknowledge of a read (R4).
    always @(negedge clk) begin
        if (rst_n && ack_oe && !ack_n_out && prev_ack_n && cur_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected ack", 32'(dbus_out), 32'hffff);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(dbus_oe === 1'b1 && dbus_out === e, "R4 read data", {15'd0, dbus_oe, dbus_out}, {16'd1, e});
            end
        end
        prev_ack_n = rst_n ? ack_n_out : 1'b1;
    end

    // One complete strobe cycle; checks the timing from R2, R3, R5 and R7.
    task automatic bus_cycle(input bit rd, input logic [16:0] a, input logic [1:0] sz,
                             input logic [15:0] wd, input int ds_delay, input int wt);
        int edges = 0;
        @(negedge clk);
        wait_cfg = wt;
        cur_rd = rd;
        if (rd) exp_q.push_back(exp_mem[a[4:1]]);
        as_n = 1'b0; cs_n = 1'b0; rd_wr_n = rd; siz = sz; addr = a; dbus_in = wd;
        ds_n = (rd || ds_delay == 0) ? 1'b0 : 1'b1;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 1) check(ack_oe === 1'b1 && ack_n_out === 1'b1, "R2 ack driven high", {ack_oe, ack_n_out}, 2'b11);
            if (ack_oe && !ack_n_out) break;
            if (!rd && ds_n) check(arr_req === 1'b0, "R5 no request before data strobe", 32'(arr_req), 0);
            if (edges == ds_delay) ds_n = 1'b0;
            if (edges > 60) begin
                check(1'b0, "R3 ack timeout", edges, 0);
                break;
            end
        end
        check(edges == ds_delay + 2 + wt, "R3 strobe to ack edges", edges, ds_delay + 2 + wt);
        if (!rd) begin
            logic [1:0] b;
            b = exp_be(sz, a[0]);
            if (b[1]) exp_mem[a[4:1]][15:8] = wd[15:8];
            if (b[0]) exp_mem[a[4:1]][7:0]  = wd[7:0];
            check(arr_be === b && arr_addr === a[16:1], "R6 lanes and word address", {arr_be, arr_addr}, {b, a[16:1]});
        end
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        check(ack_oe === 1'b1 && ack_n_out === 1'b1 && dbus_oe === 1'b0, "R7 ack high, data released",
              {ack_oe, ack_n_out, dbus_oe}, 3'b110);
        @(negedge clk);
        check(ack_oe === 1'b0 && dbus_oe === 1'b0, "R7 ack floated", {ack_oe, dbus_oe}, 2'b00);
        cs_n = 1'b1; cur_rd = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 16'(i * 16'h1111) ^ 16'h0f0f;
            exp_mem[i] = 16'(i * 16'h1111) ^ 16'h0f0f;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(ack_oe === 1'b0 && dbus_oe === 1'b0 && arr_req === 1'b0, "R1 reset idle",
              {ack_oe, dbus_oe, arr_req}, 3'b000);

        // R3/R4: reads with zero, one and four wait states
        bus_cycle(1'b1, 17'h00004, 2'b10, 16'h0, 0, 0);
        bus_cycle(1'b1, 17'h1000a, 2'b10, 16'h0, 0, 1);
        bus_cycle(1'b1, 17'h00006, 2'b00, 16'h0, 0, 4);

        // R5/R6: word write, byte writes to even and odd addresses, late data strobe
        bus_cycle(1'b0, 17'h00002, 2'b10, 16'hbeef, 0, 0);
        bus_cycle(1'b1, 17'h00002, 2'b10, 16'h0, 0, 0);
        bus_cycle(1'b0, 17'h00008, 2'b01, 16'ha55a, 0, 1);
        bus_cycle(1'b1, 17'h00008, 2'b10, 16'h0, 0, 0);
        bus_cycle(1'b0, 17'h00011, 2'b01, 16'h3cc3, 2, 0);
        bus_cycle(1'b1, 17'h00010, 2'b10, 16'h0, 0, 2);
        bus_cycle(1'b0, 17'h0001b, 2'b10, 16'h7e81, 3, 1);
        bus_cycle(1'b1, 17'h0001a, 2'b10, 16'h0, 0, 0);

        // R8: strobe without chip select is ignored
        @(negedge clk);
        as_n = 1'b0; ds_n = 1'b0; cs_n = 1'b1; rd_wr_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(ack_oe === 1'b0 && dbus_oe === 1'b0 && arr_req === 1'b0, "R8 no chip select",
                  {ack_oe, dbus_oe, arr_req}, 3'b000);
        end
        as_n = 1'b1; ds_n = 1'b1;

        // R9: strobe withdrawn before the array is ready
        @(negedge clk);
        wait_cfg = 20;
        as_n = 1'b0; cs_n = 1'b0; rd_wr_n = 1'b1; addr = 17'h4; ds_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(ack_n_out === 1'b1, "R9 no ack while waiting", 32'(ack_n_out), 1);
        end
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        check(ack_oe === 1'b1 && ack_n_out === 1'b1 && dbus_oe === 1'b0, "R9 release after abort",
              {ack_oe, ack_n_out, dbus_oe}, 3'b110);
        @(negedge clk);
        check(ack_oe === 1'b0 && arr_req === 1'b0, "R9 idle after abort", {ack_oe, arr_req}, 2'b00);
        cs_n = 1'b1;
        wait_cfg = 0;

        // R1: idle state between cycles
        repeat (2) @(negedge clk);
        check(ack_oe === 1'b0 && dbus_oe === 1'b0 && arr_req === 1'b0 && exp_q.size() == 0, "R1 idle between cycles",
              {ack_oe, dbus_oe, arr_req}, 3'b000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule